// File: doc/BRIEF.md
# Peripheral Clock-Enable Divider

This block derives three peripheral clock enables from one fast system clock. It does not produce new clocks. Each enable is a one-cycle pulse in the system-clock domain, and it repeats at an integer fraction of the system rate. Logic in each peripheral domain stays on the system clock and advances only on cycles where its enable is high. The three domains are the general peripheral domain, the timer domain and the external-interface domain. Each has its own 4-bit ratio field, and each has its own bit in a shared domain-disable vector. The bit positions are fixed at 2, 3 and 8 respectively.

All three dividers restart together from a synchronous reset, so domains with related ratios stay phase-aligned. A new ratio written to a field takes effect only when that domain's current period ends. This means no period is ever cut short. Disabling a domain masks its pulses but leaves its counter running, so the domain resumes in phase when it is enabled again. The timer domain must run at an integer multiple of the general domain's rate. A registered configuration-error flag reports any pair of ratios that breaks this rule.

Top module: `pced_clk_en_div`

## Requirements
- R1: With ratio field F, a domain's enable is high for exactly one system-clock cycle in every F+1 cycles.
- R2: While reset is high, all enables and the error flag are low. After reset is released, every domain's first pulse follows the (F+1)-th rising clock edge, so all domains start from a common phase.
- R3: While bit 2 of the disable vector is high, the general-domain enable stays low.
- R4: While bit 3 of the disable vector is high, the timer-domain enable stays low.
- R5: While bit 8 of the disable vector is high, the external-domain enable stays low.
- R6: Disabling one domain does not stop its divider counter and does not change the other domains. When the domain is re-enabled, its pulses fall on the same cycles they would have occupied without the disable.
- R7: Bits of the disable vector other than 2, 3 and 8 have no effect on any output.
- R8: The error flag is high one cycle after the general ratio (field+1) is not an integer multiple of the timer ratio (field+1), and low otherwise. The disable vector does not affect it.
- R9: A change to a ratio field takes effect at that domain's next terminal count. The period already in progress completes with the old ratio.
- R10: A ratio field of 0 makes the enable high on every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| div_gen | input | 4 | General-domain ratio field; divides by value+1 |
| div_tmr | input | 4 | Timer-domain ratio field; divides by value+1 |
| div_ext | input | 4 | External-domain ratio field; divides by value+1 |
| dom_dis | input | 16 | Domain-disable vector; bits 2, 3 and 8 are used |
| en_gen | output | 1 | General-domain enable pulse |
| en_tmr | output | 1 | Timer-domain enable pulse |
| en_ext | output | 1 | External-domain enable pulse |
| cfg_err | output | 1 | Timer rate is not an integer multiple of the general rate |

## Verification
The bench targets the following corner cases:

- **Mid-period ratio changes.** A divider that reloaded at once would shorten the running period, so pulses would appear before the old terminal count.
- **Disable windows over several periods.** A design that froze or cleared its counter while disabled would come back out of phase with the other domains.
- **Disable vectors with every unused bit set.** These catch decoding on the wrong bit positions.
- **Ratio extremes, including 1 and 16.** These expose off-by-one errors in the terminal count.
- **Ratio pairs that are multiples and pairs that are not.** These catch an error flag that has its operands swapped or that the disable bits can reach.

// File: rtl/pced_pkg.sv
package pced_pkg;

  localparam int unsigned NUM_DOM = 3;

  typedef enum logic [1:0] {
    DOM_GEN = 2'd0,
    DOM_TMR = 2'd1,
    DOM_EXT = 2'd2
  } dom_e;

endpackage

// File: rtl/pced_div_chan.sv
// One domain divider: free-running counter, ratio latched at terminal count,
// registered enable masked by the domain's disable bit.
module pced_div_chan #(
  parameter int unsigned DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_fld,
  input  logic             dis,
  output logic             en
);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] ratio_q;
  logic             term;
  logic             en_q;

  assign term = (cnt_q == ratio_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      ratio_q <= div_fld;
      en_q    <= 1'b0;
    end else begin
      if (term) begin
        cnt_q   <= '0;
        ratio_q <= div_fld;
      end else begin
        cnt_q   <= cnt_q + DIV_W'(1);
      end
      en_q <= term & ~dis;
    end
  end

  assign en = en_q;

endmodule

// File: rtl/pced_ratio_chk.sv
// Flags a general/timer ratio pair where the general ratio is not an
// integer multiple of the timer ratio.
module pced_ratio_chk #(
  parameter int unsigned DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] slow_fld,
  input  logic [DIV_W-1:0] fast_fld,
  output logic             err
);

  localparam int unsigned RW = DIV_W + 1;

  logic [RW-1:0] slow_n;
  logic [RW-1:0] fast_n;
  logic [RW-1:0] rem;
  logic          err_q;

  assign slow_n = {1'b0, slow_fld} + RW'(1);
  assign fast_n = {1'b0, fast_fld} + RW'(1);
  assign rem    = slow_n % fast_n;

  always_ff @(posedge clk) begin
    if (rst) err_q <= 1'b0;
    else     err_q <= |rem;
  end

  assign err = err_q;

endmodule

// File: rtl/pced_clk_en_div.sv
module pced_clk_en_div #(
  parameter int unsigned DIV_W   = 4,
  parameter int unsigned DIS_W   = 16,
  parameter int unsigned GEN_BIT = 2,
  parameter int unsigned TMR_BIT = 3,
  parameter int unsigned EXT_BIT = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_gen,
  input  logic [DIV_W-1:0] div_tmr,
  input  logic [DIV_W-1:0] div_ext,
  input  logic [DIS_W-1:0] dom_dis,
  output logic             en_gen,
  output logic             en_tmr,
  output logic             en_ext,
  output logic             cfg_err
);

  import pced_pkg::*;

  localparam int unsigned ND = NUM_DOM;
  localparam int unsigned BITPOS [ND] = '{GEN_BIT, TMR_BIT, EXT_BIT};

  logic [DIV_W-1:0] fld [ND];
  logic [ND-1:0]    dis_sel;
  logic [ND-1:0]    en_v;
  logic             unused_dis_bits;

  assign fld[int'(DOM_GEN)] = div_gen;
  assign fld[int'(DOM_TMR)] = div_tmr;
  assign fld[int'(DOM_EXT)] = div_ext;

  assign unused_dis_bits = ^dom_dis;

  for (genvar d = 0; d < ND; d++) begin : g_dom
    assign dis_sel[d] = dom_dis[BITPOS[d]];

    pced_div_chan #(.DIV_W(DIV_W)) u_chan (
      .clk     (clk),
      .rst     (rst),
      .div_fld (fld[d]),
      .dis     (dis_sel[d]),
      .en      (en_v[d])
    );
  end

  assign en_gen = en_v[int'(DOM_GEN)];
  assign en_tmr = en_v[int'(DOM_TMR)];
  assign en_ext = en_v[int'(DOM_EXT)];

  pced_ratio_chk #(.DIV_W(DIV_W)) u_rchk (
    .clk      (clk),
    .rst      (rst),
    .slow_fld (div_gen),
    .fast_fld (div_tmr),
    .err      (cfg_err)
  );

endmodule

// File: rtl/pced_chk.sv
module pced_chk #(
  parameter int unsigned DIV_W   = 4,
  parameter int unsigned DIS_W   = 16,
  parameter int unsigned GEN_BIT = 2,
  parameter int unsigned TMR_BIT = 3,
  parameter int unsigned EXT_BIT = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [DIV_W-1:0] div_gen,
  input logic [DIV_W-1:0] div_tmr,
  input logic [DIS_W-1:0] dom_dis,
  input logic             en_gen,
  input logic             en_tmr,
  input logic             en_ext,
  input logic             cfg_err
);

  localparam int unsigned GW = DIV_W + 2;
  localparam logic [GW-1:0] MAX_GAP = GW'(1 << DIV_W);

  logic [GW-1:0] gap_g;
  logic [GW-1:0] gap_t;
  logic [GW-1:0] gap_e;

  always_ff @(posedge clk) begin
    if (rst || en_gen || dom_dis[GEN_BIT]) gap_g <= '0;
    else                                   gap_g <= gap_g + GW'(1);
    if (rst || en_tmr || dom_dis[TMR_BIT]) gap_t <= '0;
    else                                   gap_t <= gap_t + GW'(1);
    if (rst || en_ext || dom_dis[EXT_BIT]) gap_e <= '0;
    else                                   gap_e <= gap_e + GW'(1);
  end

  AST_RST_QUIET: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!en_gen && !en_tmr && !en_ext && !cfg_err)); // R2

  AST_GEN_GAP: assert property (@(posedge clk) disable iff (rst)
    gap_g <= MAX_GAP); // R1

  AST_TMR_GAP: assert property (@(posedge clk) disable iff (rst)
    gap_t <= MAX_GAP); // R1

  AST_EXT_GAP: assert property (@(posedge clk) disable iff (rst)
    gap_e <= MAX_GAP); // R1

  AST_GEN_MASK: assert property (@(posedge clk) disable iff (rst)
    dom_dis[GEN_BIT] |=> !en_gen); // R3

  AST_TMR_MASK: assert property (@(posedge clk) disable iff (rst)
    dom_dis[TMR_BIT] |=> !en_tmr); // R4

  AST_EXT_MASK: assert property (@(posedge clk) disable iff (rst)
    dom_dis[EXT_BIT] |=> !en_ext); // R5

  AST_ERR_EQUAL: assert property (@(posedge clk) disable iff (rst)
    (div_gen == div_tmr) |=> !cfg_err); // R8

  AST_ERR_FASTER: assert property (@(posedge clk) disable iff (rst)
    (div_tmr > div_gen) |=> cfg_err); // R8

endmodule

bind pced_clk_en_div pced_chk #(
  .DIV_W   (DIV_W),
  .DIS_W   (DIS_W),
  .GEN_BIT (GEN_BIT),
  .TMR_BIT (TMR_BIT),
  .EXT_BIT (EXT_BIT)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .div_gen (div_gen),
  .div_tmr (div_tmr),
  .dom_dis (dom_dis),
  .en_gen  (en_gen),
  .en_tmr  (en_tmr),
  .en_ext  (en_ext),
  .cfg_err (cfg_err)
);

// File: tb/tb_pced_clk_en_div.sv
`timescale 1ns/1ps
module tb_pced_clk_en_div;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  div_gen = '0;
  logic [3:0]  div_tmr = '0;
  logic [3:0]  div_ext = '0;
  logic [15:0] dom_dis = '0;
  logic        en_gen, en_tmr, en_ext, cfg_err;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  pced_clk_en_div dut (
    .clk(clk), .rst(rst), .div_gen(div_gen), .div_tmr(div_tmr),
    .div_ext(div_ext), .dom_dis(dom_dis), .en_gen(en_gen),
    .en_tmr(en_tmr), .en_ext(en_ext), .cfg_err(cfg_err)
  );

  // {gen field, tmr field, ext field, disable vector, expected error}
  localparam logic [28:0] VEC [0:7] = '{
    {4'd0,  4'd0,  4'd0,  16'h0000, 1'b0},
    {4'd3,  4'd1,  4'd2,  16'h0000, 1'b0},
    {4'd2,  4'd1,  4'd15, 16'h0000, 1'b1},
    {4'd7,  4'd3,  4'd4,  16'h0004, 1'b0},
    {4'd5,  4'd2,  4'd6,  16'h0108, 1'b0},
    {4'd15, 4'd15, 4'd1,  16'hFEF3, 1'b0},
    {4'd1,  4'd3,  4'd0,  16'h010C, 1'b1},
    {4'd11, 4'd5,  4'd9,  16'h0000, 1'b0}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit exp_en(input int k, input int n, input bit dis);
    return ((k % n) == 0) && !dis;
  endfunction

  task automatic start(input logic [3:0] g, input logic [3:0] t,
                       input logic [3:0] e, input logic [15:0] dv);
    @(negedge clk);
    rst = 1'b1;
    div_gen = g; div_tmr = t; div_ext = e; dom_dis = dv;
    repeat (2) @(negedge clk);
    chk({en_gen, en_tmr, en_ext, cfg_err} == 4'b0000, "R2 reset outputs",
        int'({en_gen, en_tmr, en_ext, cfg_err}), 0);
    rst = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R1 watchdog expired actual=%0d expected<%0d", 200000, 200000);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // Table-driven: ratios, alignment after reset, disable decoding, error flag
    for (int v = 0; v < 8; v++) begin
      logic [3:0]  g, t, e;
      logic [15:0] dv;
      logic        xe;
      int mg, mt, me;
      {g, t, e, dv, xe} = VEC[v];
      mg = 0; mt = 0; me = 0;
      start(g, t, e, dv);
      for (int k = 1; k <= 48; k++) begin
        @(negedge clk);
        if (en_gen != exp_en(k, int'(g) + 1, dv[2])) mg++;
        if (en_tmr != exp_en(k, int'(t) + 1, dv[3])) mt++;
        if (en_ext != exp_en(k, int'(e) + 1, dv[8])) me++;
        if (k == 2)
          chk(cfg_err == xe, $sformatf("R8 error flag vec %0d", v), int'(cfg_err), int'(xe));
      end
      chk(mg == 0, $sformatf("R1 R2 R3 R7 R10 gen mismatches vec %0d", v), mg, 0);
      chk(mt == 0, $sformatf("R1 R2 R4 R7 R10 tmr mismatches vec %0d", v), mt, 0);
      chk(me == 0, $sformatf("R1 R2 R5 R7 R10 ext mismatches vec %0d", v), me, 0);
    end

    // R9: general ratio 4 -> 2 written mid-period; R8 flag follows one cycle later
    begin
      int mg, mt;
      mg = 0; mt = 0;
      start(4'd3, 4'd3, 4'd3, 16'h0000);
      for (int k = 1; k <= 16; k++) begin
        if (k == 6) div_gen = 4'd1;
        @(negedge clk);
        if (en_gen != ((k <= 8) ? exp_en(k, 4, 1'b0) : exp_en(k, 2, 1'b0))) mg++;
        if (en_tmr != exp_en(k, 4, 1'b0)) mt++;
        if (k == 5) chk(cfg_err == 1'b0, "R8 flag before update", int'(cfg_err), 0);
        if (k == 6) chk(cfg_err == 1'b1, "R8 flag after update", int'(cfg_err), 1);
      end
      chk(mg == 0, "R9 gen reload at terminal count", mg, 0);
      chk(mt == 0, "R9 tmr unaffected by gen update", mt, 0);
    end

    // R6: timer disabled for a window; counter keeps phase, others untouched
    begin
      int mg, mt, me;
      mg = 0; mt = 0; me = 0;
      start(4'd2, 4'd2, 4'd2, 16'h0000);
      for (int k = 1; k <= 30; k++) begin
        dom_dis = (k >= 7 && k <= 15) ? 16'h0008 : 16'h0000;
        @(negedge clk);
        if (en_gen != exp_en(k, 3, 1'b0)) mg++;
        if (en_tmr != exp_en(k, 3, (k >= 7 && k <= 15))) mt++;
        if (en_ext != exp_en(k, 3, 1'b0)) me++;
        if (k == 18) chk(en_tmr == 1'b1, "R6 tmr pulse in phase after re-enable", int'(en_tmr), 1);
      end
      chk(mt == 0, "R6 R4 tmr window mismatches", mt, 0);
      chk(mg + me == 0, "R6 other domains mismatches", mg + me, 0);
    end

    // R9 R10: external ratio 16 -> 1 written early; old period completes first
    begin
      int me;
      me = 0;
      start(4'd0, 4'd0, 4'd15, 16'h0000);
      for (int k = 1; k <= 24; k++) begin
        if (k == 3) div_ext = 4'd0;
        @(negedge clk);
        if (en_ext != (k >= 16)) me++;
      end
      chk(me == 0, "R9 R10 ext slow-to-fast reload", me, 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule